// File: doc/BRIEF.md
# Page-Mode Nonvolatile Parallel Memory Controller

This block is a synchronous front end for an asynchronous, byte-wide nonvolatile RAM with 128K locations. A host issues one request at a time through a valid/ready port. A request is a single byte, or a burst of up to eight bytes inside one aligned 8-byte page. The controller drives the memory's active-low chip enable, output enable and write enable, the 17-bit address, and the enable and data of the bidirectional data bus. Read bytes come back one per beat, each flagged by a one-clock valid pulse.

Each timing interval is set in nanoseconds and converted to whole clocks by ceiling division against the clock-period parameter. A single switch selects the timing set for either the faster or the slower supply range. After reset the controller waits out a power-up delay before it accepts a request. Each chip-enable cycle is padded to the minimum active time and is followed by an enforced precharge gap. Writes are write-enable controlled: write enable falls and rises only while chip enable is already low. Within a burst only address bits 2..0 step. A burst that would leave its page, or a request with zero beats, is rejected without touching the memory.

Top module: `nvram_page_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low and all three strobes stay high for ceil(POWERUP_NS / clock period) clocks (62500 at the 4 ns default). After that, `req_ready` rises.
- R2: A write is write-enable controlled. `mem_we_n` is low only while `mem_ce_n` is low. It is high in the first and last clock of every chip-enable cycle. The byte on `mem_dq_out` is stored at the rising edge of `mem_we_n`.
- R3: Every low pulse of `mem_we_n` lasts at least ceil(18 ns / period) clocks (5 at default). Successive write beats of a burst start at least ceil(30 ns / period) clocks apart.
- R4: Every chip-enable cycle keeps `mem_ce_n` low for at least ceil(60 ns / period) clocks (15 at default).
- R5: Between two chip-enable cycles, `mem_ce_n` stays high for at least ceil(30 ns / period) clocks (8 at default). `req_ready` stays low during this precharge.
- R6: On a read, `mem_dq_oe` is low in the first chip-enable clock, and `mem_oe_n` falls only after that clock. `mem_dq_oe` is never high while `mem_oe_n` is low. Each read byte appears on `rd_data` with a one-clock `rd_valid` pulse.
- R7: During a chip-enable cycle, address bits 16..3 stay fixed. Read beats go in ascending address order from the start offset. The first beat is sampled at least ceil(60 ns / period) clocks after chip enable falls. Each later beat is sampled at least ceil(30 ns / period) clocks after bits 2..0 change.
- R8: A burst write stores `req_wdata[8i+7:8i]` at start address + i for beat i. Address and data are held for the whole low pulse of write enable.
- R9: A request with `req_len` = 0, or with start offset (bits 2..0) + `req_len` > 8, produces a one-clock `req_err` pulse in the next clock. It produces no strobe and leaves the memory unchanged.
- R10: With SLOW_SUPPLY = 1, the chip-enable active time is at least ceil(70 ns / period) clocks (18) and the precharge gap is at least ceil(35 ns / period) clocks (9).
- R11: `req_ready` is high only while the controller is idle, with all strobes high. A request is taken in a clock where both `req_valid` and `req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Start byte address |
| req_len | input | 4 | Beat count, 1 to 8 |
| req_wdata | input | 64 | Write bytes; beat i uses bits 8i+7..8i |
| req_err | output | 1 | One-clock pulse: request rejected |
| rd_valid | output | 1 | One-clock pulse per read beat |
| rd_data | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Data returned by memory |

## Verification
The assertions check on every clock the strobe rules that need no data:
- write enable nested inside chip enable;
- minimum widths of the write-enable pulse, the active time and the precharge gap, all measured with counters;
- no bus drive while output enable is low;
- the one-clock lead of output enable;
- fixed upper address bits;
- a quiet bus while the controller reports ready or rejects a request.

Only the bench scenarios can show that data is correct. Its behavioural memory returns a garbage byte whenever a beat is sampled before its access time. Read-back of single bytes, full pages and partial pages then proves beat order, byte-lane mapping, timing, and that rejected bursts left the memory unchanged. The power-up wait and the slow-supply timing set are also measured only in scenarios.

// File: rtl/nvram_page_ctrl.sv
module nvram_page_ctrl #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter bit SLOW_SUPPLY   = 1'b0,
  parameter int POWERUP_NS    = 250000,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int PAGE_BEATS    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [$clog2(PAGE_BEATS):0]  req_len,
  input  logic [DATA_W*PAGE_BEATS-1:0] req_wdata,
  output logic                         req_err,
  output logic                         rd_valid,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         mem_ce_n,
  output logic                         mem_oe_n,
  output logic                         mem_we_n,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_dq_out,
  output logic                         mem_dq_oe,
  input  logic [DATA_W-1:0]            mem_dq_in
);

  function automatic int to_cyc(input int ns);
    return (ns * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  endfunction

  function automatic int at_least(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  localparam int OFS_W    = $clog2(PAGE_BEATS);
  localparam int LEN_W    = OFS_W + 1;
  localparam int ACT_NS   = SLOW_SUPPLY ? 70 : 60;
  localparam int PRE_NS   = SLOW_SUPPLY ? 35 : 30;
  localparam int PACC_NS  = SLOW_SUPPLY ? 40 : 30;
  localparam int PWC_NS   = SLOW_SUPPLY ? 40 : 30;
  localparam int WP_NS    = SLOW_SUPPLY ? 22 : 18;
  localparam int ACT_CYC  = at_least(to_cyc(ACT_NS), 2);
  localparam int PRE_CYC  = at_least(to_cyc(PRE_NS), 1);
  localparam int PACC_CYC = at_least(to_cyc(PACC_NS), 1);
  localparam int WP_CYC   = at_least(to_cyc(WP_NS), 1);
  localparam int REC_CYC  = at_least(to_cyc(PWC_NS) - WP_CYC, 1);
  localparam int PU_CYC   = at_least(to_cyc(POWERUP_NS), 1);
  localparam int TMR_W    = $clog2(ACT_CYC + PRE_CYC + PACC_CYC + WP_CYC + REC_CYC + 1);
  localparam int PU_W     = $clog2(PU_CYC + 1);

  typedef enum logic [3:0] {
    S_PWRUP, S_IDLE, S_RD_LEAD, S_RD_WAIT,
    S_WR_SETUP, S_WR_PULSE, S_WR_REC, S_HOLD, S_PRECH
  } state_t;

  state_t                      state;
  logic [TMR_W-1:0]            tmr;
  logic [TMR_W-1:0]            act_cnt;
  logic [PU_W-1:0]             pu_cnt;
  logic [LEN_W-1:0]            left;
  logic                        wr_q;
  logic [ADDR_W-1:0]           addr_q;
  logic [DATA_W*PAGE_BEATS-1:0] wbuf;
  logic                        err_q, rdv_q;
  logic [DATA_W-1:0]           rdd_q;
  logic [LEN_W:0]              span;
  logic                        req_bad, ce_on;

  assign span    = {{(LEN_W + 1 - OFS_W){1'b0}}, req_addr[OFS_W-1:0]} + {1'b0, req_len};
  assign req_bad = (req_len == '0) || (span > (LEN_W+1)'(PAGE_BEATS));
  assign ce_on   = state inside {S_RD_LEAD, S_RD_WAIT, S_WR_SETUP, S_WR_PULSE, S_WR_REC, S_HOLD};

  assign req_ready  = (state == S_IDLE);
  assign req_err    = err_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign mem_ce_n   = !ce_on;
  assign mem_oe_n   = (state != S_RD_WAIT);
  assign mem_we_n   = (state != S_WR_PULSE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wbuf[DATA_W-1:0];
  assign mem_dq_oe  = wr_q && ce_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_PWRUP;
      tmr     <= '0;
      act_cnt <= '0;
      pu_cnt  <= '0;
      left    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wbuf    <= '0;
      err_q   <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      err_q <= 1'b0;
      rdv_q <= 1'b0;
      if (ce_on && act_cnt != TMR_W'(ACT_CYC - 1))
        act_cnt <= act_cnt + 1'b1;
      case (state)
        S_PWRUP:
          if (pu_cnt == PU_W'(PU_CYC - 1)) state <= S_IDLE;
          else pu_cnt <= pu_cnt + 1'b1;
        S_IDLE:
          if (req_valid) begin
            if (req_bad) begin
              err_q <= 1'b1;
            end else begin
              addr_q  <= req_addr;
              left    <= req_len;
              wr_q    <= req_write;
              wbuf    <= req_wdata;
              act_cnt <= '0;
              state   <= req_write ? S_WR_SETUP : S_RD_LEAD;
            end
          end
        S_RD_LEAD: begin
          tmr   <= TMR_W'(ACT_CYC - 2);
          state <= S_RD_WAIT;
        end
        S_RD_WAIT:
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            rdv_q <= 1'b1;
            rdd_q <= mem_dq_in;
            left  <= left - 1'b1;
            if (left == LEN_W'(1)) begin
              state <= S_HOLD;
            end else begin
              addr_q[OFS_W-1:0] <= addr_q[OFS_W-1:0] + 1'b1;
              tmr <= TMR_W'(PACC_CYC - 1);
            end
          end
        S_WR_SETUP: begin
          tmr   <= TMR_W'(WP_CYC - 1);
          state <= S_WR_PULSE;
        end
        S_WR_PULSE:
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            left <= left - 1'b1;
            if (left == LEN_W'(1)) begin
              state <= S_HOLD;
            end else begin
              addr_q[OFS_W-1:0] <= addr_q[OFS_W-1:0] + 1'b1;
              wbuf  <= wbuf >> DATA_W;
              tmr   <= TMR_W'(REC_CYC - 1);
              state <= S_WR_REC;
            end
          end
        S_WR_REC:
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            tmr   <= TMR_W'(WP_CYC - 1);
            state <= S_WR_PULSE;
          end
        S_HOLD:
          if (act_cnt == TMR_W'(ACT_CYC - 1)) begin
            tmr   <= TMR_W'(PRE_CYC - 1);
            state <= S_PRECH;
          end
        S_PRECH:
          if (tmr != '0) tmr <= tmr - 1'b1;
          else state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvram_page_ctrl_chk.sv
module nvram_page_ctrl_chk #(
  parameter int ACT_CYC = 2,
  parameter int PRE_CYC = 1,
  parameter int WP_CYC  = 1,
  parameter int PU_CYC  = 1,
  parameter int ADDR_W  = 17,
  parameter int OFS_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_err,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam int SAT = 32'h3FFF_FFFF;
  int lo_cnt, hi_cnt, we_lo, since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= 0;
      we_lo  <= 0;
      since  <= 0;
    end else begin
      lo_cnt <= mem_ce_n ? 0 : ((lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt);
      hi_cnt <= !mem_ce_n ? 0 : ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt);
      we_lo  <= mem_we_n ? 0 : ((we_lo < SAT) ? we_lo + 1 : we_lo);
      since  <= (since < SAT) ? since + 1 : since;
    end
  end

  AST_POWERUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> since >= PU_CYC); // R1
  AST_WE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R2
  AST_WE_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> mem_we_n); // R2
  AST_CE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $past(mem_we_n)); // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> we_lo >= WP_CYC); // R3
  AST_CE_ACTIVE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> lo_cnt >= ACT_CYC); // R4
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> hi_cnt >= PRE_CYC); // R5
  AST_NO_DRIVE_ON_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R6
  AST_OE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (!$past(mem_dq_oe) && !$past(mem_ce_n))); // R6
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])); // R7
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (mem_ce_n && req_ready)); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && hi_cnt >= PRE_CYC)); // R11

endmodule

bind nvram_page_ctrl nvram_page_ctrl_chk #(
  .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC), .WP_CYC(WP_CYC),
  .PU_CYC(PU_CYC), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/nvram_page_ctrl_tb.sv
module nvram_page_ctrl_tb;
  localparam int T_PS     = 4000;
  localparam int ACT      = (60000 + T_PS - 1) / T_PS;
  localparam int PRE      = (30000 + T_PS - 1) / T_PS;
  localparam int WP       = (18000 + T_PS - 1) / T_PS;
  localparam int PACC     = (30000 + T_PS - 1) / T_PS;
  localparam int PU       = (250000000 + T_PS - 1) / T_PS;
  localparam int SACT     = (70000 + T_PS - 1) / T_PS;
  localparam int SPRE     = (35000 + T_PS - 1) / T_PS;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, req_err, rd_valid;
  logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [16:0] mem_addr;

  nvram_page_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .req_err(req_err), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  logic        s_valid = 1'b0;
  logic        s_ready, s_err, s_rdv, s_ce_n, s_oe_n, s_we_n, s_dq_oe;
  logic [7:0]  s_rdd, s_dq_out;
  logic [16:0] s_addr;

  nvram_page_ctrl #(.SLOW_SUPPLY(1'b1)) u_slow (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
    .req_write(1'b0), .req_addr(17'h00040), .req_len(4'd1),
    .req_wdata(64'h0), .req_err(s_err), .rd_valid(s_rdv),
    .rd_data(s_rdd), .mem_ce_n(s_ce_n), .mem_oe_n(s_oe_n),
    .mem_we_n(s_we_n), .mem_addr(s_addr), .mem_dq_out(s_dq_out),
    .mem_dq_oe(s_dq_oe), .mem_dq_in(8'h00));

  int n_checks = 0, n_fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural memory: garbage until access time has elapsed
  logic [7:0]  mem     [logic [16:0]];
  logic [7:0]  ref_mem [logic [16:0]];
  logic [7:0]  exp_q   [$];
  logic [16:0] m_pa = '0;
  int          m_aage = 0, m_cage = 0;
  logic        m_pce = 1'b1;

  always @(posedge clk) begin
    m_pa   <= mem_addr;
    m_aage <= (mem_addr != m_pa) ? 0 : m_aage + 1;
    m_pce  <= mem_ce_n;
    m_cage <= (mem_ce_n || m_pce) ? 0 : m_cage + 1;
  end

  always @* begin
    int aeff, ceff;
    aeff = (mem_addr != m_pa) ? 0 : m_aage + 1;
    ceff = mem_ce_n ? 0 : (m_pce ? 0 : m_cage + 1);
    if (!mem_ce_n && !mem_oe_n && ceff >= ACT - 1 && aeff >= PACC - 1)
      mem_dq_in = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    else
      mem_dq_in = 8'hEE;
  end

  // port monitor: strobe timing, writes into the model, scoreboard
  int   ce_run = 0, hi_run = 1 << 20, we_run = 0;
  bit   prev_ce = 1'b1, prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0;
  logic [13:0] up0 = '0;
  bit   up_changed = 1'b0, we_outside = 1'b0, wr_unstable = 1'b0;
  bit   drive_on_oe = 1'b0, ready_bad = 1'b0;
  logic [16:0] w_addr = '0;
  logic [7:0]  w_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) begin
        if (prev_ce) begin
          chk(hi_run >= PRE, "R5 precharge gap", hi_run, PRE);
          ce_run = 1; up0 = mem_addr[16:3];
        end else begin
          ce_run++;
          if (mem_addr[16:3] != up0) up_changed = 1'b1;
        end
      end else begin
        if (!prev_ce) begin
          chk(ce_run >= ACT, "R4 chip-enable active time", ce_run, ACT);
          chk(prev_we, "R2 write enable high at last active clock", prev_we, 1);
          hi_run = 1;
        end else hi_run++;
      end
      if (!mem_we_n) begin
        if (mem_ce_n) we_outside = 1'b1;
        if (prev_we) begin
          chk(!prev_ce, "R2 write enable after chip enable", prev_ce, 0);
          we_run = 1; w_addr = mem_addr; w_data = mem_dq_out;
        end else begin
          we_run++;
          if (mem_addr != w_addr || mem_dq_out != w_data || !mem_dq_oe) wr_unstable = 1'b1;
        end
      end else if (!prev_we) begin
        chk(we_run >= WP, "R3 write pulse width", we_run, WP);
        mem[w_addr] = w_data;
      end
      if (!mem_oe_n && prev_oe)
        chk(!mem_dq_oe && !prev_dqoe && !prev_ce, "R6 output enable lead", mem_dq_oe, 0);
      if (!mem_oe_n && mem_dq_oe) drive_on_oe = 1'b1;
      if (req_ready && (!mem_ce_n || hi_run <= PRE)) ready_bad = 1'b1;
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read beat", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R7 read beat data", rd_data, e);
        end
      end
      prev_ce = mem_ce_n; prev_we = mem_we_n; prev_oe = mem_oe_n; prev_dqoe = mem_dq_oe;
    end
  end

  // slow-supply instance monitor
  int  s_run = 0, s_hi = 1 << 20, s_seen = 0;
  bit  s_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!s_ce_n) begin
        if (s_prev) begin
          if (s_seen > 0) chk(s_hi >= SPRE, "R10 slow precharge gap", s_hi, SPRE);
          s_run = 1;
        end else s_run++;
      end else begin
        if (!s_prev) begin
          chk(s_run >= SACT, "R10 slow active time", s_run, SACT);
          s_seen++; s_hi = 1;
        end else s_hi++;
      end
      s_prev = s_ce_n;
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [3:0] len, input logic [63:0] wd);
    wait_ready();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = wd;
    for (int i = 0; i < int'(len); i++) begin
      if (wr) ref_mem[a + 17'(i)] = wd[8*i +: 8];
      else exp_q.push_back(ref_mem.exists(a + 17'(i)) ? ref_mem[a + 17'(i)] : 8'h00);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reject(input bit wr, input logic [16:0] a, input logic [3:0] len);
    bit quiet;
    wait_ready();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = 64'hDEAD_BEEF_CAFE_F00D;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b1, "R9 reject pulse", req_err, 1);
    quiet = mem_ce_n && req_ready;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!mem_ce_n || !mem_we_n || req_err) quiet = 1'b0;
    end
    chk(quiet, "R9 no strobe after reject", quiet, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      chk(1'b0, "watchdog expired", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int wait_cyc;
    repeat (3) @(negedge clk);
    chk(!req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n}, 4'b0111);
    rst_n = 1'b1;
    wait_cyc = 0;
    @(negedge clk);
    while (!req_ready) begin
      if (!mem_ce_n || !mem_we_n || !mem_oe_n) chk(1'b0, "R1 strobe during power-up", 0, 1);
      wait_cyc++;
      @(negedge clk);
    end
    chk(wait_cyc >= PU - 1 && wait_cyc <= PU + 1, "R1 power-up wait", wait_cyc, PU);

    // slow instance: two back-to-back reads
    s_valid = 1'b1; @(negedge clk); s_valid = 1'b0;
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; @(negedge clk); s_valid = 1'b0;

    do_op(1'b1, 17'h1ABCD, 4'd1, 64'h5A);                    // R2 single write
    do_op(1'b0, 17'h1ABCD, 4'd1, 64'h0);                     // R6 single read
    do_op(1'b0, 17'h00400, 4'd1, 64'h0);                     // R6 unwritten byte
    do_op(1'b1, 17'h00120, 4'd8, 64'h8877_6655_4433_2211);   // R8 full page write
    do_op(1'b0, 17'h00120, 4'd8, 64'h0);                     // R7 full page read
    do_op(1'b1, 17'h1FFFB, 4'd5, 64'h00_00_00_E5_D4_C3_B2_A1); // R8 offset burst to page end
    do_op(1'b0, 17'h1FFFD, 4'd3, 64'h0);                     // R7 partial read
    do_op(1'b0, 17'h00123, 4'd2, 64'h0);                     // R7 mid-page read
    do_reject(1'b1, 17'h1FFFD, 4'd4);                        // R9 crossing write
    do_reject(1'b0, 17'h00120, 4'd0);                        // R9 zero length
    do_reject(1'b1, 17'h00120, 4'd9);                        // R9 overlong
    do_op(1'b0, 17'h1FFFD, 4'd3, 64'h0);                     // R9 memory unchanged
    do_op(1'b1, 17'h00127, 4'd1, 64'h77);                    // R8 last byte of page
    do_op(1'b0, 17'h00126, 4'd2, 64'h0);

    wait_ready();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all read beats returned", exp_q.size(), 0);
    chk(!we_outside, "R2 write enable only inside chip enable", we_outside, 0);
    chk(!wr_unstable, "R8 address and data held during pulse", wr_unstable, 0);
    chk(!up_changed, "R7 upper address fixed", up_changed, 0);
    chk(!drive_on_oe, "R6 no drive with output enable", drive_on_oe, 0);
    chk(!ready_bad, "R11 ready only when idle", ready_bad, 0);
    chk(s_seen >= 2, "R10 slow instance ran", s_seen, 2);
    finish_run();
  end
endmodule